// File: doc/BRIEF.md
# Clocked Serial Receiver with Address-Wake Filter

This block is the receiving side of a clocked (synchronous) serial port. An external serial clock and a serial data line come in asynchronously. Both pass through a synchronizer chain, and the falling edges of the serial clock sample the line. A frame is a low start bit, then 7, 8 or 9 data bits sent least significant first, then an optional parity bit, then one or two stop bits. The stop bits are counted and not checked. The character completes on the first rising serial-clock edge after its last stop bit. A completed character goes into a receive buffer and raises a buffer-full flag and an optional interrupt.

An address-wake (attention) mode lets several receivers share one line. While the attention bit is set, characters whose ninth bit is 0 are thrown away. The first character with ninth bit 1 is an address. It is accepted, and the attention bit clears by itself so that all later characters pass. Software sets the attention bit again to go back to waiting for an address. A loop-back diagnostic mode takes the receive data from the local transmitter output and forces the 9-bit, no-parity format.

Top module: `srx_top`

## Requirements
- R1: After reset, rxFull, overrun, parityErr, atnBit, irq, rxBit9 and rxData are all 0.
- R2: In idle, a falling serial-clock edge that samples the line low starts a frame. Each later falling edge samples one bit, and data bits arrive least significant bit first.
- R3: fmtSel 00 selects 7 data bits, 01 selects 8 and 1x selects 9. rxData[7:0] holds data bits 0..7, with bit 7 at 0 for a 7-bit frame. rxBit9 holds the ninth data bit of a 9-bit frame and 0 otherwise.
- R4: The frame length is 1 + data bits + parityEn + (twoStop ? 2 : 1). The buffer loads and rxFull sets SYNC_STAGES+1 clock cycles after the first rising serial-clock edge that follows the last stop bit's falling edge.
- R5: A one-cycle rdBuf pulse clears rxFull. If a load happens in the same cycle, rxFull stays 1.
- R6: When an accepted character completes while rxFull is 1 and rdBuf is not asserted, the buffer is overwritten and overrun sets. A statRd pulse clears overrun, and a new set in the same cycle wins.
- R7: With parityEn set, the received parity bit is checked. Even parity (parityOdd=0) needs an even number of ones across the data and parity bits; odd parity needs an odd number. A mismatch on an accepted character sets parityErr until statRd.
- R8: While atnBit is 1 in the 9-bit, no-parity format, a character with ninth bit 0 has no effect on rxData, rxBit9, rxFull, overrun or parityErr.
- R9: In that state, a character with ninth bit 1 is loaded and clears atnBit. After that, every character is accepted until software sets atnBit again.
- R10: atnWr loads atnWrData into atnBit and takes priority over the automatic clear in the same cycle.
- R11: With diagMode set, loopData replaces serData as the line input, and the format is forced to 9 data bits with no parity, whatever fmtSel and parityEn say.
- R12: irq equals rxFull AND irqEn.
- R13: When the effective format is not 9-bit without parity, atnBit has no filtering effect and is not cleared by received characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock, asynchronous |
| serData | input | 1 | Serial data line, asynchronous |
| loopData | input | 1 | Transmitter output used in diagnostic mode |
| diagMode | input | 1 | Loop-back diagnostic mode enable |
| fmtSel | input | 2 | Data length select: 00=7, 01=8, 1x=9 |
| parityEn | input | 1 | Parity bit present and checked |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| twoStop | input | 1 | Two stop bits when 1 |
| irqEn | input | 1 | Interrupt enable |
| rdBuf | input | 1 | Host read strobe for the buffer |
| statRd | input | 1 | Host status read strobe, clears the sticky errors |
| atnWr | input | 1 | Write strobe for the attention bit |
| atnWrData | input | 1 | Value written to the attention bit |
| rxData | output | 8 | Receive buffer, low eight data bits |
| rxBit9 | output | 1 | Received ninth data bit |
| rxFull | output | 1 | Receive buffer full |
| overrun | output | 1 | Sticky overrun flag |
| parityErr | output | 1 | Sticky parity error flag |
| atnBit | output | 1 | Attention (address-wait) bit |
| irq | output | 1 | Receive interrupt |

## Verification
The embedded assertions check, on every cycle, the links between strobes and flags. A buffer load is always followed by rxFull. A read with no load clears it. Overrun and parity error rise only on a load. An address accepted under attention clears atnBit, and a ninth-bit-0 character under attention never loads. irq never shows without rxFull. Only the bench's frame scenarios can show the end-to-end behaviour, checked against a behavioural model on every clock: bit order and field placement for each format, the exact completion cycle, parity polarity, write priority on the attention bit, attention being inert in other formats, and the loop-back substitution.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int MAX_DATA = 9;
  localparam int IDX_W = 4;

  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_DONE} srx_state_t;

  typedef struct packed {
    logic             clearSh;
    logic             capBit;
    logic             capPar;
    logic             loadBuf;
    logic             bitVal;
    logic [IDX_W-1:0] bitIdx;
  } srx_stb_t;
endpackage

// File: rtl/srx_dp.sv
module srx_dp
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  srx_stb_t   stb,
  input  logic       parityOdd,
  output logic       shBit9,
  output logic       parityBad,
  output logic [7:0] rxData,
  output logic       rxBit9
);
  logic [MAX_DATA-1:0] shReg;
  logic                parReg;

  for (genvar i = 0; i < MAX_DATA; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shReg[i] <= 1'b0;
      else if (stb.clearSh) shReg[i] <= 1'b0;
      else if (stb.capBit && stb.bitIdx == IDX_W'(i)) shReg[i] <= stb.bitVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) parReg <= 1'b0;
    else if (stb.clearSh) parReg <= 1'b0;
    else if (stb.capPar) parReg <= stb.bitVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxBit9 <= 1'b0;
    end else if (stb.loadBuf) begin
      rxData <= shReg[7:0];
      rxBit9 <= shReg[MAX_DATA-1];
    end
  end

  assign shBit9    = shReg[MAX_DATA-1];
  assign parityBad = (^shReg) ^ parReg ^ parityOdd;

  // R2
  bit_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capBit |-> (stb.bitIdx < IDX_W'(MAX_DATA)));
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       rawData,
  input  logic       diagMode,
  input  logic [1:0] fmtSel,
  input  logic       parityEn,
  input  logic       twoStop,
  input  logic       rdBuf,
  input  logic       statRd,
  input  logic       atnWr,
  input  logic       atnWrData,
  input  logic       shBit9,
  input  logic       parityBad,
  output srx_stb_t   stb,
  output logic       rxFull,
  output logic       overrun,
  output logic       parityErr,
  output logic       atnBit
);
  logic [SYNC_STAGES-1:0] clkSync, datSync;
  logic clkPrev, clkNow, datNow, fallEdge, riseEdge;
  srx_state_t state, stateNxt;
  logic [IDX_W-1:0] bitCnt, bitCntNxt, nBits, lastIdx;
  logic parOn, atnActive, addrHit, markBad;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkSync[0] <= 1'b1;
          datSync[0] <= 1'b1;
        end else begin
          clkSync[0] <= serClk;
          datSync[0] <= rawData;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkSync[i] <= 1'b1;
          datSync[i] <= 1'b1;
        end else begin
          clkSync[i] <= clkSync[i-1];
          datSync[i] <= datSync[i-1];
        end
      end
    end
  end

  assign clkNow   = clkSync[SYNC_STAGES-1];
  assign datNow   = datSync[SYNC_STAGES-1];
  assign fallEdge = clkPrev & ~clkNow;
  assign riseEdge = ~clkPrev & clkNow;

  always_comb begin
    if (diagMode) nBits = IDX_W'(MAX_DATA);
    else begin
      unique case (fmtSel)
        2'b00:   nBits = IDX_W'(7);
        2'b01:   nBits = IDX_W'(8);
        default: nBits = IDX_W'(9);
      endcase
    end
  end

  assign parOn     = parityEn & ~diagMode;
  assign lastIdx   = nBits + IDX_W'(parOn) + (twoStop ? IDX_W'(2) : IDX_W'(1)) - IDX_W'(1);
  assign atnActive = atnBit && (nBits == IDX_W'(MAX_DATA)) && !parOn;

  always_comb begin
    stb        = '0;
    stb.bitIdx = bitCnt;
    stb.bitVal = datNow;
    stateNxt   = state;
    bitCntNxt  = bitCnt;
    addrHit    = 1'b0;
    markBad    = 1'b0;
    unique case (state)
      RX_IDLE: begin
        if (fallEdge && !datNow) begin
          stb.clearSh = 1'b1;
          stateNxt    = RX_BITS;
          bitCntNxt   = '0;
        end
      end
      RX_BITS: begin
        if (fallEdge) begin
          stb.capBit = (bitCnt < nBits);
          stb.capPar = parOn && (bitCnt == nBits);
          bitCntNxt  = bitCnt + IDX_W'(1);
          if (bitCnt == lastIdx) stateNxt = RX_DONE;
        end
      end
      default: begin
        if (riseEdge) begin
          stateNxt    = RX_IDLE;
          stb.loadBuf = !(atnActive && !shBit9);
          addrHit     = atnActive && shBit9;
          markBad     = parOn && parityBad;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= RX_IDLE;
      bitCnt    <= '0;
      clkPrev   <= 1'b1;
      rxFull    <= 1'b0;
      overrun   <= 1'b0;
      parityErr <= 1'b0;
      atnBit    <= 1'b0;
    end else begin
      state   <= stateNxt;
      bitCnt  <= bitCntNxt;
      clkPrev <= clkNow;
      if (stb.loadBuf) rxFull <= 1'b1;
      else if (rdBuf) rxFull <= 1'b0;
      if (stb.loadBuf && rxFull && !rdBuf) overrun <= 1'b1;
      else if (statRd) overrun <= 1'b0;
      if (stb.loadBuf && markBad) parityErr <= 1'b1;
      else if (statRd) parityErr <= 1'b0;
      if (atnWr) atnBit <= atnWrData;
      else if (addrHit) atnBit <= 1'b0;
    end
  end

  // R4
  full_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadBuf |=> rxFull);
  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdBuf && !stb.loadBuf) |=> !rxFull);
  // R6
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(stb.loadBuf && rxFull));
  // R7
  parity_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> $past(stb.loadBuf));
  // R8
  atn_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_DONE && riseEdge && atnActive && !shBit9) |-> !stb.loadBuf);
  // R9
  atn_autoclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadBuf && atnActive && !atnWr) |=> !atnBit);
endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       loopData,
  input  logic       diagMode,
  input  logic [1:0] fmtSel,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       twoStop,
  input  logic       irqEn,
  input  logic       rdBuf,
  input  logic       statRd,
  input  logic       atnWr,
  input  logic       atnWrData,
  output logic [7:0] rxData,
  output logic       rxBit9,
  output logic       rxFull,
  output logic       overrun,
  output logic       parityErr,
  output logic       atnBit,
  output logic       irq
);
  srx_stb_t stb;
  logic shBit9, parityBad, rawData;

  assign rawData = diagMode ? loopData : serData;

  srx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .rawData(rawData),
    .diagMode(diagMode), .fmtSel(fmtSel), .parityEn(parityEn), .twoStop(twoStop),
    .rdBuf(rdBuf), .statRd(statRd), .atnWr(atnWr), .atnWrData(atnWrData),
    .shBit9(shBit9), .parityBad(parityBad), .stb(stb),
    .rxFull(rxFull), .overrun(overrun), .parityErr(parityErr), .atnBit(atnBit)
  );

  srx_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .parityOdd(parityOdd),
    .shBit9(shBit9), .parityBad(parityBad), .rxData(rxData), .rxBit9(rxBit9)
  );

  assign irq = rxFull & irqEn;

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rxFull && irqEn));
endmodule

// File: tb/tb_srx_top.sv
`timescale 1ns/1ps
module tb_srx_top;
  localparam int SYNC = 2;
  localparam int HALF = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic serClk = 1'b1, line = 1'b1, useLoop = 1'b0;
  logic serData, loopData;
  logic diagMode = 0, parityEn = 0, parityOdd = 0, twoStop = 0, irqEn = 0;
  logic rdBuf = 0, statRd = 0, atnWr = 0, atnWrData = 0;
  logic [1:0] fmtSel = 2'b01;
  logic [7:0] rxData;
  logic rxBit9, rxFull, overrun, parityErr, atnBit, irq;

  int nTests = 0, nFail = 0, cycles = 0;
  bit done = 0;

  assign serData  = useLoop ? 1'b0 : line;
  assign loopData = useLoop ? line : 1'b1;

  always #2.5 clk = ~clk;

  srx_top #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .loopData(loopData),
    .diagMode(diagMode), .fmtSel(fmtSel), .parityEn(parityEn), .parityOdd(parityOdd),
    .twoStop(twoStop), .irqEn(irqEn), .rdBuf(rdBuf), .statRd(statRd), .atnWr(atnWr),
    .atnWrData(atnWrData), .rxData(rxData), .rxBit9(rxBit9), .rxFull(rxFull),
    .overrun(overrun), .parityErr(parityErr), .atnBit(atnBit), .irq(irq)
  );

  // behavioural reference model
  int cq[SYNC], dq[SYNC];
  int cPrev, mSt, mCnt, mSh, mPar;
  int mData, mB9, mFull, mOv, mPe, mAtn;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC; i++) begin cq[i] = 1; dq[i] = 1; end
      cPrev = 1; mSt = 0; mCnt = 0; mSh = 0; mPar = 0;
      mData = 0; mB9 = 0; mFull = 0; mOv = 0; mPe = 0; mAtn = 0;
    end else begin
      int c, d, nb, pe, tot, load, bad, clr, b9, ones;
      bit fall, rise;
      c = cq[SYNC-1]; d = dq[SYNC-1];
      fall = (cPrev == 1 && c == 0); rise = (cPrev == 0 && c == 1);
      nb = diagMode ? 9 : (fmtSel == 2'b00 ? 7 : (fmtSel == 2'b01 ? 8 : 9));
      pe = (parityEn && !diagMode) ? 1 : 0;
      tot = nb + pe + (twoStop ? 2 : 1);
      load = 0; bad = 0; clr = 0; b9 = 0;
      if (mSt == 0) begin
        if (fall && d == 0) begin mSt = 1; mCnt = 0; mSh = 0; mPar = 0; end
      end else if (mSt == 1) begin
        if (fall) begin
          if (mCnt < nb) mSh = mSh | (d << mCnt);
          else if (pe == 1 && mCnt == nb) mPar = d;
          if (mCnt == tot - 1) mSt = 2;
          mCnt++;
        end
      end else if (rise) begin
        bit act;
        mSt = 0;
        b9 = (mSh >> 8) & 1;
        act = (mAtn == 1) && nb == 9 && pe == 0;
        if (!(act && b9 == 0)) begin
          load = 1;
          ones = 0;
          for (int i = 0; i < 9; i++) ones += (mSh >> i) & 1;
          ones += mPar;
          bad = (pe == 1) && ((ones % 2) != (parityOdd ? 1 : 0));
        end
        clr = (act && b9 == 1) ? 1 : 0;
      end
      if (load == 1 && mFull == 1 && !rdBuf) mOv = 1; else if (statRd) mOv = 0;
      if (load == 1 && bad == 1) mPe = 1; else if (statRd) mPe = 0;
      if (load == 1) mFull = 1; else if (rdBuf) mFull = 0;
      if (atnWr) mAtn = atnWrData ? 1 : 0; else if (clr == 1) mAtn = 0;
      if (load == 1) begin mData = mSh & 8'hFF; mB9 = b9; end
      cPrev = c;
      for (int i = SYNC - 1; i > 0; i--) begin cq[i] = cq[i-1]; dq[i] = dq[i-1]; end
      cq[0] = serClk;
      dq[0] = diagMode ? loopData : serData;
    end
  end

  task automatic chk(string tag, string nm, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R3", "rxData model", rxData, mData);
      chk("R3", "rxBit9 model", rxBit9, mB9);
      chk("R4", "rxFull model", rxFull, mFull);
      chk("R6", "overrun model", overrun, mOv);
      chk("R7", "parityErr model", parityErr, mPe);
      chk("R9", "atnBit model", atnBit, mAtn);
      chk("R12", "irq model", irq, mFull & irqEn);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(int b);
    line = b[0];
    waitN(HALF);
    serClk = 1'b0;
    waitN(HALF);
    serClk = 1'b1;
  endtask

  // parMode: -1 none, 0 even-correct, 1 odd-correct, 2 force wrong even
  task automatic sendFrame(int val, int nb, int parMode, int stops);
    int ones = 0;
    sendBit(0);
    for (int i = 0; i < nb; i++) begin
      sendBit((val >> i) & 1);
      ones += (val >> i) & 1;
    end
    if (parMode == 0) sendBit(ones % 2);
    else if (parMode == 1) sendBit(1 - (ones % 2));
    else if (parMode == 2) sendBit(1 - (ones % 2));
    for (int i = 0; i < stops; i++) sendBit(1);
    sendBit(1);
    waitN(6);
  endtask

  task automatic pulseRd();
    rdBuf = 1; waitN(1); rdBuf = 0; waitN(1);
  endtask

  task automatic pulseStat();
    statRd = 1; waitN(1); statRd = 0; waitN(1);
  endtask

  task automatic writeAtn(bit v);
    atnWr = 1; atnWrData = v; waitN(1); atnWr = 0; atnWrData = 0; waitN(1);
  endtask

  initial begin
    waitN(4);
    rstN = 1;
    waitN(2);
    // R1 reset state
    chk("R1", "rxFull", rxFull, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "parityErr", parityErr, 0);
    chk("R1", "atnBit", atnBit, 0);
    chk("R1", "rxData", rxData, 0);
    chk("R1", "irq", irq, 0);
    waitN(4);

    // R2 LSB first, 8-bit
    fmtSel = 2'b01;
    sendFrame(8'h1D, 8, -1, 1);
    chk("R2", "rxData lsb-first", rxData, 8'h1D);
    chk("R4", "rxFull set", rxFull, 1);
    chk("R12", "irq masked", irq, 0);
    irqEn = 1; waitN(1);
    chk("R12", "irq enabled", irq, 1);
    pulseRd();
    chk("R5", "rxFull cleared", rxFull, 0);
    chk("R12", "irq cleared", irq, 0);

    // R3 / R7 7-bit with even parity
    fmtSel = 2'b00; parityEn = 1; parityOdd = 0;
    sendFrame(7'h55, 7, 0, 1);
    chk("R3", "7-bit data", rxData, 8'h55);
    chk("R7", "even ok", parityErr, 0);
    pulseRd();
    sendFrame(7'h13, 7, 2, 1);
    chk("R7", "even bad", parityErr, 1);
    pulseStat();
    chk("R7", "stat clears", parityErr, 0);
    pulseRd();
    parityOdd = 1; fmtSel = 2'b01;
    sendFrame(8'hC4, 8, 1, 2);
    chk("R7", "odd ok", parityErr, 0);
    chk("R3", "8-bit parity data", rxData, 8'hC4);
    pulseRd();
    parityEn = 0;

    // R6 overrun
    sendFrame(8'h11, 8, -1, 1);
    sendFrame(8'h22, 8, -1, 1);
    chk("R6", "overrun set", overrun, 1);
    chk("R6", "overwrite", rxData, 8'h22);
    pulseStat();
    chk("R6", "overrun cleared", overrun, 0);
    chk("R6", "full kept", rxFull, 1);
    pulseRd();

    // R3 9-bit two stops
    fmtSel = 2'b10; twoStop = 1;
    sendFrame(9'h1A5, 9, -1, 2);
    chk("R3", "9-bit data", rxData, 8'hA5);
    chk("R3", "ninth bit", rxBit9, 1);
    pulseRd();
    twoStop = 0;

    // R8 / R9 attention
    writeAtn(1);
    chk("R9", "atn set", atnBit, 1);
    sendFrame(9'h042, 9, -1, 1);
    chk("R8", "data dropped full", rxFull, 0);
    chk("R8", "data dropped value", rxData, 8'hA5);
    chk("R8", "atn kept", atnBit, 1);
    sendFrame(9'h1C3, 9, -1, 1);
    chk("R9", "address loaded", rxData, 8'hC3);
    chk("R9", "atn auto-clear", atnBit, 0);
    pulseRd();
    sendFrame(9'h011, 9, -1, 1);
    chk("R9", "later data passes", rxData, 8'h11);
    chk("R9", "later data full", rxFull, 1);
    pulseRd();

    // R10 write priority over auto-clear
    atnWr = 1; atnWrData = 1;
    sendFrame(9'h1E7, 9, -1, 1);
    chk("R10", "address loaded", rxData, 8'hE7);
    chk("R10", "write wins", atnBit, 1);
    atnWr = 0; atnWrData = 0;
    pulseRd();

    // R13 attention inert in 8-bit format
    fmtSel = 2'b01;
    sendFrame(8'h33, 8, -1, 1);
    chk("R13", "accepted", rxData, 8'h33);
    chk("R13", "atn unchanged", atnBit, 1);
    pulseRd();
    writeAtn(0);

    // R11 loop-back diagnostic
    parityEn = 1; fmtSel = 2'b00;
    diagMode = 1; useLoop = 1;
    waitN(6);
    sendFrame(9'h1B2, 9, -1, 1);
    chk("R11", "loop data", rxData, 8'hB2);
    chk("R11", "loop ninth", rxBit9, 1);
    chk("R11", "no parity", parityErr, 0);
    pulseRd();
    diagMode = 0; useLoop = 0; parityEn = 0;
    waitN(10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule